// File: doc/BRIEF.md
# Converter Sample-Window Sequencer

This block paces the sampling windows of an analog-to-digital converter and turns the raw code delivered at the end of each window into a result word. A configuration write sets three fields: a run flag, a sample-rate select and a three-bit window-length code. A separate level input tells the block whether the system clock is the fast (24 MHz) or the slow (12 MHz) source. From either source the block derives 6 MHz and 1 MHz tick enables, so every window lasts the same time in microseconds whichever source is running.

When the run flag is written to one from the stopped state, the block waits a fixed analog settling time of 21 µs (21 ticks of the 1 MHz enable). It then runs windows back to back until the run flag is written to zero. The first window after a start is thrown away. A configuration write while running also throws away the next window, and so does a change of the clock-source input. Neither of those repeats the settling wait. Every kept window produces one 16-bit, left-aligned result. Bits below the significant count for the chosen window length read as zero. A one-cycle valid strobe marks each result.

Top module: `adc_seq_top`

## Requirements
- R1: After reset `result_vld` is 0 and `result` is 16'h0000.
- R2: After a write with `cfg_en_in`=1 from the stopped state at clock edge W, the first `result_vld` is seen after edge W + 1 + 21·D1 + 2·L·Ds. D1 is 24 when `sys_hi`=1 and 12 when `sys_hi`=0. Ds is the system cycles per sample tick and L is the window length.
- R3: While running, consecutive `result_vld` pulses are exactly L·Ds system cycles apart.
- R4: `cfg_slow_in`=0 selects the 6 MHz tick, with Ds = 4 at `sys_hi`=1 and 2 at `sys_hi`=0. `cfg_slow_in`=1 selects the 1 MHz tick, with Ds = 24 or 12 in the same way.
- R5: The window-length code N (`cfg_period_in`, 0..7) gives L = 32·2^N sample ticks.
- R6: `result` equals `raw_data` as sampled on the window's last edge, ANDed with 16'hFFFF << (11 − N). Only the top 5+N bits survive.
- R7: `result_vld` is high for exactly one cycle per kept window.
- R8: A write with `cfg_en_in`=1 while already enabled and running, at edge W, discards the current and the next window. The next `result_vld` comes after edge W + 2·L·Ds, computed from the newly written fields.
- R9: A write with `cfg_en_in`=1 during the settling wait does not lengthen the wait or shift the first result.
- R10: A change of `sys_hi` while running restarts at the first edge E that sees the new value. The next `result_vld` comes after edge E + 2·L·Ds, with Ds for the new source.
- R11: A write with `cfg_en_in`=0 stops the block at once, and no `result_vld` follows until it is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (24 MHz or 12 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe, one cycle |
| cfg_en_in | input | 1 | Run flag written on `cfg_wr` |
| cfg_slow_in | input | 1 | Sample-rate select written on `cfg_wr` (1 = 1 MHz) |
| cfg_period_in | input | 3 | Window-length code N written on `cfg_wr` |
| sys_hi | input | 1 | 1 when the system clock is the 24 MHz source |
| raw_data | input | 16 | Raw converter code, taken at the end of a window |
| result | output | 16 | Masked, left-aligned result |
| result_vld | output | 1 | One-cycle strobe for a new result |

## Verification
The hardest cases to reach from the ports are restarts that land inside a window or inside the settling wait. These are a mid-window clock-source change, a mid-window reconfiguration, and a rewrite during settling. In each of them the only visible effect is the timing of the next valid strobe. The bench applies each event at a known edge and counts system cycles from that edge. It then requires the next strobe on the exact computed cycle, so an early strobe from the discarded window or a wrongly repeated wait shows up as a cycle mismatch.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int PERIOD_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WARM = 2'd1,
    ST_RUN  = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic                en;
    logic                slow;
    logic [PERIOD_W-1:0] period;
  } seq_cfg_t;

endpackage

// File: rtl/adc_seq_prescaler.sv
module adc_seq_prescaler #(
  parameter int SYS_HI_MHZ = 24,
  parameter int SYS_LO_MHZ = 12,
  parameter int FAST_MHZ   = 6,
  parameter int SLOW_MHZ   = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic sys_hi,
  output logic tick_fast,
  output logic tick_slow
);

  localparam int HI_MAX = SYS_HI_MHZ / SLOW_MHZ;
  localparam int CW     = $clog2(HI_MAX + 1);

  logic [1:0] ticks;

  genvar g;
  for (g = 0; g < 2; g++) begin : g_div
    localparam int RATE    = (g == 0) ? FAST_MHZ : SLOW_MHZ;
    localparam int DIV_HI  = SYS_HI_MHZ / RATE;
    localparam int DIV_LO  = SYS_LO_MHZ / RATE;
    localparam logic [CW-1:0] LAST_HI = CW'(DIV_HI - 1);
    localparam logic [CW-1:0] LAST_LO = CW'(DIV_LO - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;
    logic [CW-1:0] last_w;
    logic          tick_w;

    always_comb begin
      last_w = sys_hi ? LAST_HI : LAST_LO;
      tick_w = !clr && (cnt_q >= last_w);
      if (clr || tick_w) begin
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_d;
      end
    end

    assign ticks[g] = tick_w;
  end

  assign tick_fast = ticks[0];
  assign tick_slow = ticks[1];

  // Both dividers restart together, so every slow tick falls on a fast tick.
  AST_SLOW_ON_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    tick_slow |-> tick_fast); // R4

  AST_NO_TICK_IN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> !(tick_fast || tick_slow)); // R10

endmodule

// File: rtl/adc_seq_warmup.sv
module adc_seq_warmup #(
  parameter int DELAY_TICKS = 21
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic done
);

  localparam int DW = $clog2(DELAY_TICKS + 1);
  localparam logic [DW-1:0] LAST = DW'(DELAY_TICKS - 1);

  logic [DW-1:0] cnt_q;
  logic [DW-1:0] cnt_d;

  always_comb begin
    done  = tick && (cnt_q == LAST);
    cnt_d = cnt_q;
    if (clr || done) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  AST_WARM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R2

endmodule

// File: rtl/adc_seq_window.sv
module adc_seq_window #(
  parameter int BASE_CLKS = 32,
  parameter int PW        = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic [PW-1:0] period,
  output logic          last
);

  localparam int MAX_LEN = BASE_CLKS << ((1 << PW) - 1);
  localparam int WW      = $clog2(MAX_LEN);

  logic [WW:0]   len_w;
  logic [WW-1:0] len_m1;
  logic [WW-1:0] cnt_q;
  logic [WW-1:0] cnt_d;

  always_comb begin
    len_w  = (WW+1)'(BASE_CLKS) << period;
    len_m1 = WW'(len_w - 1'b1);
    last   = tick && (cnt_q == len_m1);
    cnt_d  = cnt_q;
    if (clr || last) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  AST_WCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= len_m1); // R5

endmodule

// File: rtl/adc_seq_mask.sv
module adc_seq_mask #(
  parameter int RES_W    = 16,
  parameter int MIN_BITS = 5,
  parameter int PW       = 3
) (
  input  logic [PW-1:0]    period,
  input  logic [RES_W-1:0] raw,
  output logic [RES_W-1:0] masked
);

  localparam int SHIFT_MAX = RES_W - MIN_BITS;
  localparam int SW        = $clog2(SHIFT_MAX + 1);

  logic [SW-1:0]    drop_w;
  logic [RES_W-1:0] keep_w;

  always_comb begin
    drop_w = SW'(SHIFT_MAX) - SW'(period);
    keep_w = {RES_W{1'b1}} << drop_w;
    masked = raw & keep_w;
  end

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int RES_W       = 16,
  parameter int PW          = PERIOD_W,
  parameter int BASE_CLKS   = 32,
  parameter int MIN_BITS    = 5,
  parameter int WARM_TICKS  = 21,
  parameter int SYS_HI_MHZ  = 24,
  parameter int SYS_LO_MHZ  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_en_in,
  input  logic             cfg_slow_in,
  input  logic [PW-1:0]    cfg_period_in,
  input  logic             sys_hi,
  input  logic [RES_W-1:0] raw_data,
  output logic [RES_W-1:0] result,
  output logic             result_vld
);

  seq_cfg_t   cfg_q, cfg_d;
  seq_state_e state_q, state_d;
  logic       discard_q, discard_d;
  logic       sys_hi_q;
  logic       vld_q, vld_d;
  logic [RES_W-1:0] res_q, res_d;

  logic wr_stop, wr_restart, clk_sw, restart_any;
  logic pre_clr, warm_clr, win_clr;
  logic tick_fast, tick_slow, sample_tick;
  logic warm_done, win_last;
  logic [RES_W-1:0] masked_w;

  // Write and clock-source decode
  always_comb begin
    wr_stop     = cfg_wr && !cfg_en_in;
    wr_restart  = cfg_wr && cfg_en_in && cfg_q.en;
    clk_sw      = sys_hi != sys_hi_q;
    restart_any = wr_restart || clk_sw;
    sample_tick = cfg_q.slow ? tick_slow : tick_fast;
    pre_clr     = (state_q == ST_IDLE) || clk_sw ||
                  ((state_q == ST_RUN) && wr_restart);
    warm_clr    = state_q != ST_WARM;
    win_clr     = (state_q != ST_RUN) || restart_any || wr_stop;
  end

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_wr) begin
      cfg_d.en     = cfg_en_in;
      cfg_d.slow   = cfg_slow_in;
      cfg_d.period = cfg_period_in;
    end
  end

  adc_seq_prescaler #(
    .SYS_HI_MHZ (SYS_HI_MHZ),
    .SYS_LO_MHZ (SYS_LO_MHZ),
    .FAST_MHZ   (6),
    .SLOW_MHZ   (1)
  ) u_prescaler (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (pre_clr),
    .sys_hi    (sys_hi),
    .tick_fast (tick_fast),
    .tick_slow (tick_slow)
  );

  adc_seq_warmup #(
    .DELAY_TICKS (WARM_TICKS)
  ) u_warmup (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (warm_clr),
    .tick  (tick_slow),
    .done  (warm_done)
  );

  adc_seq_window #(
    .BASE_CLKS (BASE_CLKS),
    .PW        (PW)
  ) u_window (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (win_clr),
    .tick   (sample_tick),
    .period (cfg_q.period),
    .last   (win_last)
  );

  adc_seq_mask #(
    .RES_W    (RES_W),
    .MIN_BITS (MIN_BITS),
    .PW       (PW)
  ) u_mask (
    .period (cfg_q.period),
    .raw    (raw_data),
    .masked (masked_w)
  );

  // Sequencing next state
  always_comb begin
    state_d   = state_q;
    discard_d = discard_q;
    vld_d     = 1'b0;
    res_d     = res_q;
    unique case (state_q)
      ST_IDLE: begin
        discard_d = 1'b1;
        if (cfg_q.en && !wr_stop) begin
          state_d = ST_WARM;
        end
      end
      ST_WARM: begin
        discard_d = 1'b1;
        if (wr_stop) begin
          state_d = ST_IDLE;
        end else if (warm_done) begin
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        if (wr_stop) begin
          state_d = ST_IDLE;
        end else if (restart_any) begin
          discard_d = 1'b1;
        end else if (win_last) begin
          if (discard_q) begin
            discard_d = 1'b0;
          end else begin
            vld_d = 1'b1;
            res_d = masked_w;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      state_q   <= ST_IDLE;
      discard_q <= 1'b1;
      sys_hi_q  <= 1'b1;
      vld_q     <= 1'b0;
      res_q     <= '0;
    end else begin
      cfg_q     <= cfg_d;
      state_q   <= state_d;
      discard_q <= discard_d;
      sys_hi_q  <= sys_hi;
      vld_q     <= vld_d;
      res_q     <= res_d;
    end
  end

  assign result     = res_q;
  assign result_vld = vld_q;

  AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q); // R7

  AST_VLD_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> ($past(state_q) == ST_RUN)); // R2

  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> (RES_W'(res_q << (MIN_BITS + int'(cfg_q.period))) == '0)); // R6

  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stop |=> (!vld_q && (state_q == ST_IDLE))); // R11

  AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_any && (state_q == ST_RUN)) |=> !vld_q); // R8

  AST_WARM_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_WARM) && wr_restart && !warm_done) |=> (state_q == ST_WARM)); // R9

endmodule

// File: tb/adc_seq_top_bench.sv
module adc_seq_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 190000;
  localparam int NVEC = 8;

  // {sys_hi, slow, period, raw, expected result}
  localparam logic [36:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 3'd0, 16'hFFFF, 16'hF800},
    {1'b1, 1'b1, 3'd0, 16'hABCD, 16'hA800},
    {1'b0, 1'b0, 3'd1, 16'hFFFF, 16'hFC00},
    {1'b0, 1'b1, 3'd2, 16'h1234, 16'h1200},
    {1'b1, 1'b0, 3'd3, 16'hFFFF, 16'hFF00},
    {1'b1, 1'b0, 3'd7, 16'hFFFF, 16'hFFF0},
    {1'b0, 1'b0, 3'd5, 16'h5A5A, 16'h5A40},
    {1'b1, 1'b0, 3'd6, 16'h8001, 16'h8000}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic        cfg_en_in;
  logic        cfg_slow_in;
  logic [2:0]  cfg_period_in;
  logic        sys_hi;
  logic [15:0] raw_data;
  logic [15:0] result;
  logic        result_vld;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  adc_seq_top u_adc_seq_top (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_wr        (cfg_wr),
    .cfg_en_in     (cfg_en_in),
    .cfg_slow_in   (cfg_slow_in),
    .cfg_period_in (cfg_period_in),
    .sys_hi        (sys_hi),
    .raw_data      (raw_data),
    .result        (result),
    .result_vld    (result_vld)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int div_tick(input bit hi, input bit slow);
    if (slow) return hi ? 24 : 12;
    return hi ? 4 : 2;
  endfunction

  function automatic int win_cycles(input bit hi, input bit slow, input int n);
    return (32 << n) * div_tick(hi, slow);
  endfunction

  function automatic int start_delay(input bit hi, input bit slow, input int n);
    return 1 + 21 * div_tick(hi, 1'b1) + 2 * win_cycles(hi, slow, n);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input bit en, input bit slow, input logic [2:0] n, output int at);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_en_in = en; cfg_slow_in = slow; cfg_period_in = n;
    @(posedge clk);
    #1;
    at = cyc;
    cfg_wr = 1'b0;
  endtask

  task automatic wait_vld(input int limit, output int at, output int d);
    at = -1;
    d = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (result_vld) begin
        at = cyc;
        d = int'(result);
        break;
      end
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #(CLK_PERIOD * WDOG_CYCLES);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", cyc, WDOG_CYCLES);
      summary();
      $finish;
    end
  end

  initial begin
    int w, at, d, prev;
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_en_in = 1'b0; cfg_slow_in = 1'b0;
    cfg_period_in = 3'd0; sys_hi = 1'b1; raw_data = 16'h0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(result_vld == 1'b0, "R1 vld after reset", int'(result_vld), 0);
    chk(result == 16'h0, "R1 result after reset", int'(result), 0);

    // Table walk: start delay, masking, window spacing
    for (int v = 0; v < NVEC; v++) begin
      bit hi, sl;
      logic [2:0] n;
      int exp_d;
      hi = VEC[v][36]; sl = VEC[v][35]; n = VEC[v][34:32];
      exp_d = int'(VEC[v][15:0]);
      sys_hi = hi;
      raw_data = VEC[v][31:16];
      wr_cfg(1'b0, 1'b0, 3'd0, w);
      repeat (3) @(negedge clk);
      wr_cfg(1'b1, sl, n, w);
      wait_vld(start_delay(hi, sl, int'(n)) + 50, at, d);
      chk(at == w + start_delay(hi, sl, int'(n)), "R2 R4 R5 first result cycle",
          at - w, start_delay(hi, sl, int'(n)));
      chk(d == exp_d, "R6 masked result", d, exp_d);
      @(negedge clk);
      chk(result_vld == 1'b0, "R7 valid one cycle", int'(result_vld), 0);
      prev = at;
      wait_vld(win_cycles(hi, sl, int'(n)) + 50, at, d);
      chk(at - prev == win_cycles(hi, sl, int'(n)), "R3 back-to-back spacing",
          at - prev, win_cycles(hi, sl, int'(n)));
    end

    // R8: reconfigure mid-window, new period takes effect after one discard
    wr_cfg(1'b0, 1'b0, 3'd0, w);
    sys_hi = 1'b1;
    raw_data = 16'hFFFF;
    repeat (3) @(negedge clk);
    wr_cfg(1'b1, 1'b0, 3'd0, w);
    wait_vld(start_delay(1'b1, 1'b0, 0) + 50, at, d);
    repeat (40) @(negedge clk);
    wr_cfg(1'b1, 1'b0, 3'd1, w);
    wait_vld(2 * win_cycles(1'b1, 1'b0, 1) + 50, at, d);
    chk(at - w == 2 * win_cycles(1'b1, 1'b0, 1), "R8 restart after write",
        at - w, 2 * win_cycles(1'b1, 1'b0, 1));
    chk(d == 16'hFC00, "R8 R6 new period mask", d, 16'hFC00);

    // R10: clock-source switch mid-window
    repeat (30) @(negedge clk);
    sys_hi = 1'b0;
    @(posedge clk);
    #1;
    w = cyc;
    wait_vld(2 * win_cycles(1'b0, 1'b0, 1) + 50, at, d);
    chk(at - w == 2 * win_cycles(1'b0, 1'b0, 1), "R10 restart on clock switch",
        at - w, 2 * win_cycles(1'b0, 1'b0, 1));
    prev = at;
    wait_vld(win_cycles(1'b0, 1'b0, 1) + 50, at, d);
    chk(at - prev == win_cycles(1'b0, 1'b0, 1), "R10 R4 spacing on slow source",
        at - prev, win_cycles(1'b0, 1'b0, 1));

    // R11: disable mid-window, nothing further
    repeat (20) @(negedge clk);
    wr_cfg(1'b0, 1'b0, 3'd1, w);
    wait_vld(3000, at, d);
    chk(at == -1, "R11 no result after stop", at, -1);

    // R9: rewrite during settling wait keeps the first result on time
    sys_hi = 1'b1;
    repeat (3) @(negedge clk);
    wr_cfg(1'b1, 1'b0, 3'd0, prev);
    repeat (100) @(negedge clk);
    wr_cfg(1'b1, 1'b0, 3'd0, w);
    wait_vld(start_delay(1'b1, 1'b0, 0) + 50, at, d);
    chk(at - prev == start_delay(1'b1, 1'b0, 0), "R9 settling not repeated",
        at - prev, start_delay(1'b1, 1'b0, 0));

    // R11: stop during settling produces nothing
    wr_cfg(1'b0, 1'b0, 3'd0, w);
    repeat (3) @(negedge clk);
    wr_cfg(1'b1, 1'b0, 3'd0, w);
    repeat (200) @(negedge clk);
    wr_cfg(1'b0, 1'b0, 3'd0, w);
    wait_vld(1500, at, d);
    chk(at == -1, "R11 stop during settling", at, -1);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule